// File: doc/BRIEF.md
# Base-Integer Subset Instruction Decoder

This block turns a 32-bit base-integer instruction word into the control and operand fields that a simple core needs. It covers four instruction classes: register-register ALU operations, register-immediate ALU operations, word loads and word stores. The outputs are the three register addresses, a 4-bit ALU operation code, an operand select, a register-file write enable, load and store strobes, and a sign-extended immediate.

The control signals are not taken from a full opcode table. Most of them come from one opcode bit, with a few small gates that correct the cases where that bit would give the wrong answer for stores and immediates. The only full opcode compares are the load and store strobes, and those strobes drive the corrections. All outputs are registered: the decode of the word seen at one rising clock edge appears on the outputs right after that edge. This lets the block sit as the register boundary between fetch and execute.

Top module: `rvdec_top`

## Requirements
- R1: The source addresses always come from fixed bit positions, whatever the instruction class: the first source from bits 19:15 and the second source from bits 24:20. The destination address always comes from bits 11:7.
- R2: `load_o` is 1 exactly when bits 6:0 equal 0000011. Every other opcode gives 0.
- R3: `store_o` is 1 exactly when bits 6:0 equal 0100011. Every other opcode gives 0.
- R4: `alu_src_reg_o` is 1 (second operand from the register file) when opcode bit 5 is 1 and the word is not a store. Otherwise it is 0, which selects the immediate.
- R5: For words that are neither loads nor stores, `alu_op_o` is {bit 30 AND opcode bit 5, bits 14:12}. A 1 in bit 30 therefore marks subtract only in register-register words, and never in an immediate word.
- R6: `alu_op_o` is 0000 (add) whenever the word is a load or a store, whatever bits 30 and 14:12 hold.
- R7: `rf_we_o` is the inverse of the store strobe.
- R8: For every non-store word, `imm_o` is bits 31:20 sign-extended from bit 31 to 32 bits.
- R9: For a store, `imm_o` is {bits 31:25, bits 11:7} sign-extended from bit 31 to 32 bits.
- R10: Outputs are registered. The decode of the word present at a rising edge of `clk_i` appears just after that edge. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word to decode |
| rs1_o | output | 5 | First source register address |
| rs2_o | output | 5 | Second source register address |
| rd_o | output | 5 | Destination register address |
| alu_op_o | output | 4 | ALU operation: {subtract flag, funct3} |
| alu_src_reg_o | output | 1 | 1 = register operand, 0 = immediate operand |
| rf_we_o | output | 1 | Register-file write enable |
| load_o | output | 1 | Word-load strobe |
| store_o | output | 1 | Word-store strobe |
| imm_o | output | 32 | Sign-extended immediate |

## Verification
On a store, two corrections act in the same cycle. The immediate multiplexer swaps in the split offset, while the ALU-operation override and the operand-select gate hide opcode bit 5, which is 1 for stores. The bench provokes both at once with store words that carry bit 30 set, a nonzero funct3 and a negative split offset. It then judges `alu_op_o`, `alu_src_reg_o`, `rf_we_o` and `imm_o` together against a model built from the requirements. The same clash is tried on immediate words whose constant sets bit 30, which must still decode as a plain add-class operation.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int unsigned ILEN      = 32;
    localparam int unsigned RADDR_W   = 5;
    localparam int unsigned FUNCT3_W  = 3;
    localparam int unsigned ALUOP_W   = FUNCT3_W + 1;
    localparam int unsigned OPC_W     = 7;
    localparam int unsigned IMM_RAW_W = 12;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;

    // opcode bit separating register and immediate forms
    localparam int unsigned OPC_REGSEL_BIT = 5;
    // instruction bit that flags subtract in register-register words
    localparam int unsigned SUB_FLAG_BIT   = 30;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic               src_reg;
        logic               rf_we;
        logic               ld;
        logic               st;
    } ctrl_t;

    typedef struct packed {
        logic [RADDR_W-1:0] rs1;
        logic [RADDR_W-1:0] rs2;
        logic [RADDR_W-1:0] rd;
    } regs_t;

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0]    opcode_i,
    input  logic [FUNCT3_W-1:0] funct3_i,
    input  logic                sub_flag_i,
    output ctrl_t               ctrl_o
);

    logic is_ld;
    logic is_st;
    logic sub_ok;

    always_comb begin
        is_ld  = (opcode_i == OPC_LOAD);
        is_st  = (opcode_i == OPC_STORE);
        sub_ok = sub_flag_i & opcode_i[OPC_REGSEL_BIT];

        ctrl_o.ld      = is_ld;
        ctrl_o.st      = is_st;
        ctrl_o.src_reg = opcode_i[OPC_REGSEL_BIT] & ~is_st;
        ctrl_o.rf_we   = ~is_st;
        if (is_ld | is_st) begin
            ctrl_o.alu_op = '0;
        end else begin
            ctrl_o.alu_op = {sub_ok, funct3_i};
        end
    end

    // R2 R3
    always_comb begin
        ld_st_onehot_chk: assert (!(is_ld && is_st));
    end

endmodule

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [ILEN-16:0]    upper_i,   // instruction bits 31:15
    input  logic [RADDR_W-1:0]  low5_i,    // instruction bits 11:7
    input  logic                store_i,
    output regs_t               regs_o,
    output logic [XLEN-1:0]     imm_o
);

    localparam int unsigned EXT_W = XLEN - IMM_RAW_W;

    logic [IMM_RAW_W-1:0] raw_i_form;
    logic [IMM_RAW_W-1:0] raw_s_form;
    logic [IMM_RAW_W-1:0] raw_sel;

    always_comb begin
        regs_o.rs1 = upper_i[4:0];
        regs_o.rs2 = upper_i[9:5];
        regs_o.rd  = low5_i;

        raw_i_form = upper_i[16:5];
        raw_s_form = {upper_i[16:10], low5_i};
        raw_sel    = store_i ? raw_s_form : raw_i_form;
    end

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_o = {{EXT_W{raw_sel[IMM_RAW_W-1]}}, raw_sel};
        end else begin : g_noext
            assign imm_o = raw_sel[XLEN-1:0];
        end
    endgenerate

    // R8 R9
    always_comb begin
        imm_sign_chk: assert (imm_o[XLEN-1] == upper_i[16]);
    end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ILEN-1:0]     instr_i,
    output logic [RADDR_W-1:0]  rs1_o,
    output logic [RADDR_W-1:0]  rs2_o,
    output logic [RADDR_W-1:0]  rd_o,
    output logic [ALUOP_W-1:0]  alu_op_o,
    output logic                alu_src_reg_o,
    output logic                rf_we_o,
    output logic                load_o,
    output logic                store_o,
    output logic [XLEN-1:0]     imm_o
);

    typedef struct packed {
        ctrl_t           ctrl;
        regs_t           regs;
        logic [XLEN-1:0] imm;
    } stage_t;

    ctrl_t           ctrl_w;
    regs_t           regs_w;
    logic [XLEN-1:0] imm_w;
    stage_t          stage_d;
    stage_t          stage_q;

    rvdec_ctrl u_ctrl (
        .opcode_i   (instr_i[OPC_W-1:0]),
        .funct3_i   (instr_i[14:12]),
        .sub_flag_i (instr_i[SUB_FLAG_BIT]),
        .ctrl_o     (ctrl_w)
    );

    rvdec_fields #(.XLEN(XLEN)) u_fields (
        .upper_i (instr_i[ILEN-1:15]),
        .low5_i  (instr_i[11:7]),
        .store_i (ctrl_w.st),
        .regs_o  (regs_w),
        .imm_o   (imm_w)
    );

    always_comb begin
        stage_d.ctrl = ctrl_w;
        stage_d.regs = regs_w;
        stage_d.imm  = imm_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rs1_o         = stage_q.regs.rs1;
    assign rs2_o         = stage_q.regs.rs2;
    assign rd_o          = stage_q.regs.rd;
    assign alu_op_o      = stage_q.ctrl.alu_op;
    assign alu_src_reg_o = stage_q.ctrl.src_reg;
    assign rf_we_o       = stage_q.ctrl.rf_we;
    assign load_o        = stage_q.ctrl.ld;
    assign store_o       = stage_q.ctrl.st;
    assign imm_o         = stage_q.imm;

    // cycles-since-reset marker for the checks below
    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    // R6
    addr_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_o || store_o) |-> (alu_op_o == '0));

    // R7
    store_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store_o |-> !rf_we_o);

    // R4
    store_immsrc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store_o |-> !alu_src_reg_o);

    // R5
    imm_nosub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && !$past(instr_i[OPC_REGSEL_BIT])) |-> !alu_op_o[ALUOP_W-1]);

    // R9
    store_offs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && store_o) |-> (imm_o[4:0] == $past(instr_i[11:7])));

    // R1
    rs1_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> (rs1_o == $past(instr_i[19:15])));

endmodule

// File: tb/tb_rvdec_top.sv
module tb_rvdec_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr;
    logic [4:0]  rs1, rs2, rd;
    logic [3:0]  alu_op;
    logic        src_reg, we, ld, st;
    logic [31:0] imm;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    rvdec_top dut (
        .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
        .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd),
        .alu_op_o(alu_op), .alu_src_reg_o(src_reg), .rf_we_o(we),
        .load_o(ld), .store_o(st), .imm_o(imm)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    function automatic logic [31:0] exp_imm(input logic [31:0] w);
        logic signed [11:0] s;
        if (w[6:0] == 7'h23) s = {w[31:25], w[11:7]};
        else                 s = w[31:20];
        return 32'($signed(s));
    endfunction

    function automatic logic [3:0] exp_op(input logic [31:0] w);
        if (w[6:0] == 7'h03 || w[6:0] == 7'h23) return 4'd0;
        return {(w[6:0] == 7'h33 || w[5]) ? w[30] & w[5] : 1'b0, w[14:12]};
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] want);
        if (got !== want) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, want);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        logic is_st;
        @(negedge clk);
        instr = w;
        @(posedge clk);
        #2;
        vectors++;
        is_st = (w[6:0] == 7'h23);
        cmp("R1", "rs1", 32'(rs1), 32'(w[19:15]));
        cmp("R1", "rs2", 32'(rs2), 32'(w[24:20]));
        cmp("R1", "rd",  32'(rd),  32'(w[11:7]));
        cmp("R2", "load", 32'(ld), 32'(w[6:0] == 7'b0000011));
        cmp("R3", "store", 32'(st), 32'(is_st));
        cmp("R4", "src_reg", 32'(src_reg), 32'(w[5] && !is_st));
        cmp("R5/R6", "alu_op", 32'(alu_op), 32'(exp_op(w)));
        cmp("R7", "we", 32'(we), 32'(!is_st));
        cmp(is_st ? "R9" : "R8", "imm", imm, exp_imm(w));
    endtask

    function automatic logic [31:0] rnd_class(input int k);
        logic [31:0] w = $urandom();
        case (k)
            0: w[6:0] = 7'b0110011;
            1: w[6:0] = 7'b0010011;
            2: w[6:0] = 7'b0000011;
            3: w[6:0] = 7'b0100011;
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        #50000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0;
        instr = 32'h4000_50b3;
        repeat (2) @(posedge clk);
        #2;
        // R10 reset state
        vectors++;
        cmp("R10", "reset outputs",
            {imm[31:10], rs1, rs2, alu_op, src_reg, we, ld, st},
            32'd0);
        cmp("R10", "reset imm", imm, 32'd0);
        @(negedge clk);
        rst_n = 1;

        // R5 sub: bit30 set, R-type -> 1000
        apply(32'h4030_80b3);
        // R5 addi whose constant sets bit30 -> msb 0
        apply(32'h4001_0093);
        // R8 most negative and -1 immediate
        apply(32'h8000_0013);
        apply(32'hFFF0_0013);
        // R2 R6 lw with funct3 nonzero and bit30 set
        apply(32'h4FF7_2283);
        // R9 R6 R4 sw, bit30 set, funct3 7, negative split offset
        apply(32'hC0A7_7FA3);
        apply(32'h0000_00A3);
        // near-miss opcodes for R2 R3
        apply(32'h4000_0023 | 32'h0000_0004);
        apply(32'h4000_0007);

        for (int i = 0; i < 400; i++) begin
            apply(rnd_class(int'($urandom_range(0, 4))));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule